// File: doc/BRIEF.md
# Completion Ring Producer with Pass Stamping

This block takes completion entries of eight 32-bit words from a valid/ready stream and writes each one, a word per cycle, into a circular ring held in external memory. Every entry written to the main ring carries a 4-bit pass stamp. The stamp changes each time the producer goes round the ring. A consumer can therefore tell fresh slots from stale ones by looking at the stamp alone, without first reading the producer's head index.

An entry whose internal-error flag is set goes to a separate error ring instead. In such an entry the stamp field carries a 4-bit error code supplied with the entry. The flag is raised upstream in two cases: a plain buffer pointer was sent toward the idle link-descriptor ring, or a link-descriptor pointer was sent toward the buffer ring. Each ring has its own head index, a consumer tail input and a fullness test. The two rings never block each other.

Top module: `cmpl_ring_writer`

## Requirements
- R1: After reset, both head outputs are 0, no write enable is asserted, and `in_ready` is 1 while both tails are 0.
- R2: An accepted entry is written as eight consecutive single-word writes. They start in the cycle after acceptance, in word order 0 to 7, at address slot*8 + word, where slot is the target ring's head.
- R3: A ring's head advances by one in the cycle after the write of word 7 and does not change at any other time. It wraps from the last slot (depth-1) to 0.
- R4: In the main ring, bits 31:28 of word 7 hold the pass stamp. The stamp is 1 for entries written on the first traversal after reset, and it goes up by one on each wrap of the main head.
- R5: The stamp wraps from 15 to 0. Entries of consecutive passes differ in stamp bit 0.
- R6: An entry with bit 31 of word 2 set (word k occupies `in_entry[32k+31:32k]`) is written only to the error ring. Its word 7 bits 31:28 carry `in_err_code`, and the main head is left unchanged.
- R7: Apart from word 7 bits 31:28, every word is written exactly as received.
- R8: `in_ready` is 0 when advancing the head of the ring chosen by the presented entry would make it equal to that ring's tail. A full ring does not stop entries bound for the other ring.
- R9: `in_ready` is 0 while an entry's words are being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry presented |
| in_ready | output | 1 | Entry can be taken this cycle |
| in_entry | input | 256 | Eight words, word k at bits 32k+31:32k |
| in_err_code | input | 4 | Code placed in error-ring entries |
| main_tail | input | 3 | Consumer index of the main ring |
| main_head | output | 3 | Producer index of the main ring |
| main_wr_en | output | 1 | Main ring word write |
| main_wr_addr | output | 6 | Main ring word address |
| main_wr_data | output | 32 | Main ring word data |
| err_tail | input | 2 | Consumer index of the error ring |
| err_head | output | 2 | Producer index of the error ring |
| err_wr_en | output | 1 | Error ring word write |
| err_wr_addr | output | 5 | Error ring word address |
| err_wr_data | output | 32 | Error ring word data |

## Verification
The hardest case to reach is the stamp rolling from 15 back to 0. It takes sixteen full traversals of the main ring, and the consumer has to keep pace the whole time. The bench's consumer copies each head onto its tail, and it streams 136 main entries with error entries mixed in. Before that, it holds both tails at 0 to fill the main ring, shows that error entries still pass, and then fills the error ring as well.

// File: rtl/cmpl_ring_pkg.sv
package cmpl_ring_pkg;
  // word that carries the internal-error flag in its top bit
  localparam int ERR_WORD = 2;
  // word whose top bits carry the pass stamp or the error code
  localparam int TAG_WORD = 7;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic             full
);
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return i + IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] head_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       head_q <= '0;
    else if (advance) head_q <= next_idx(head_q);
  end

  assign head = head_q;
  assign full = (next_idx(head_q) == tail);

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> head == IDX_W'($past(head) + IDX_W'(1)));  // R3
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(head));  // R3
endmodule

// File: rtl/pass_counter.sv
module pass_counter #(
  parameter int IDX_W  = 3,
  parameter int PASS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [IDX_W-1:0]  head,
  output logic [PASS_W-1:0] pass
);
  logic              wrap_evt;
  logic [PASS_W-1:0] pass_q;

  assign wrap_evt = advance && (&head);

  always_ff @(posedge clk) begin
    if (!rst_n)        pass_q <= '0;
    else if (wrap_evt) pass_q <= pass_q + PASS_W'(1);
  end

  assign pass = pass_q;

  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> pass[0] != $past(pass[0]));  // R5
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(pass));  // R4
endmodule

// File: rtl/entry_sequencer.sv
module entry_sequencer #(
  parameter int ENTRY_WORDS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           busy,
  output logic [$clog2(ENTRY_WORDS)-1:0] widx,
  output logic                           last
);
  localparam int WIDX_W = $clog2(ENTRY_WORDS);
  localparam logic [WIDX_W-1:0] FINAL_W = WIDX_W'(ENTRY_WORDS - 1);

  logic              busy_q;
  logic [WIDX_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == FINAL_W) busy_q <= 1'b0;
      else                  cnt_q  <= cnt_q + WIDX_W'(1);
    end
  end

  assign busy = busy_q;
  assign widx = cnt_q;
  assign last = busy_q && (cnt_q == FINAL_W);

  AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy && widx == WIDX_W'($past(widx) + WIDX_W'(1)));  // R2
  AST_SEQ_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);  // R9
endmodule

// File: rtl/cmpl_ring_writer.sv
module cmpl_ring_writer
  import cmpl_ring_pkg::*;
#(
  parameter int MAIN_IDX_W  = 3,
  parameter int ERR_IDX_W   = 2,
  parameter int WORD_W      = 32,
  parameter int ENTRY_WORDS = 8,
  parameter int PASS_W      = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  output logic                                          in_ready,
  input  logic [WORD_W*ENTRY_WORDS-1:0]                 in_entry,
  input  logic [PASS_W-1:0]                             in_err_code,
  input  logic [MAIN_IDX_W-1:0]                         main_tail,
  output logic [MAIN_IDX_W-1:0]                         main_head,
  output logic                                          main_wr_en,
  output logic [MAIN_IDX_W+$clog2(ENTRY_WORDS)-1:0]     main_wr_addr,
  output logic [WORD_W-1:0]                             main_wr_data,
  input  logic [ERR_IDX_W-1:0]                          err_tail,
  output logic [ERR_IDX_W-1:0]                          err_head,
  output logic                                          err_wr_en,
  output logic [ERR_IDX_W+$clog2(ENTRY_WORDS)-1:0]      err_wr_addr,
  output logic [WORD_W-1:0]                             err_wr_data
);
  localparam int WIDX_W     = $clog2(ENTRY_WORDS);
  localparam int ENTRY_BITS = WORD_W * ENTRY_WORDS;
  localparam int FLAG_POS   = ERR_WORD * WORD_W + WORD_W - 1;
  localparam logic [WIDX_W-1:0] TAG_IDX = WIDX_W'(TAG_WORD);

  function automatic logic [PASS_W-1:0] stamp_of(input logic [PASS_W-1:0] p);
    return p + PASS_W'(1);
  endfunction

  logic                  busy, last;
  logic [WIDX_W-1:0]     widx;
  logic                  main_full, err_full;
  logic [PASS_W-1:0]     main_pass;
  logic                  in_is_err, accept;
  logic                  main_adv, err_adv;
  logic [ENTRY_BITS-1:0] ent_q;
  logic                  is_err_q;
  logic [PASS_W-1:0]     tag_q;
  logic [WORD_W-1:0]     cur_word;

  assign in_is_err = in_entry[FLAG_POS];
  assign in_ready  = !busy && (in_is_err ? !err_full : !main_full);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q    <= '0;
      is_err_q <= 1'b0;
      tag_q    <= '0;
    end else if (accept) begin
      ent_q    <= in_entry;
      is_err_q <= in_is_err;
      tag_q    <= in_is_err ? in_err_code : stamp_of(main_pass);
    end
  end

  entry_sequencer #(.ENTRY_WORDS(ENTRY_WORDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .widx(widx), .last(last)
  );

  assign main_adv = last && !is_err_q;
  assign err_adv  = last && is_err_q;

  ring_ptr #(.IDX_W(MAIN_IDX_W)) main_ptr_i (
    .clk(clk), .rst_n(rst_n), .advance(main_adv), .tail(main_tail),
    .head(main_head), .full(main_full)
  );

  ring_ptr #(.IDX_W(ERR_IDX_W)) err_ptr_i (
    .clk(clk), .rst_n(rst_n), .advance(err_adv), .tail(err_tail),
    .head(err_head), .full(err_full)
  );

  pass_counter #(.IDX_W(MAIN_IDX_W), .PASS_W(PASS_W)) pass_i (
    .clk(clk), .rst_n(rst_n), .advance(main_adv), .head(main_head),
    .pass(main_pass)
  );

  always_comb begin
    cur_word = ent_q[widx*WORD_W +: WORD_W];
    if (widx == TAG_IDX) cur_word[WORD_W-1 -: PASS_W] = tag_q;
  end

  assign main_wr_en   = busy && !is_err_q;
  assign err_wr_en    = busy && is_err_q;
  assign main_wr_addr = {main_head, widx};
  assign err_wr_addr  = {err_head, widx};
  assign main_wr_data = cur_word;
  assign err_wr_data  = cur_word;

  AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (main_wr_en != err_wr_en) && widx == '0);  // R2
  AST_ERR_SPARES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr_en |=> $stable(main_head));  // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (main_wr_en || err_wr_en) |-> !in_ready);  // R9
endmodule

// File: tb/cmpl_ring_writer_tb.sv
module cmpl_ring_writer_tb_top;
  localparam int CLK_P = 10;
  localparam int MI = 3;
  localparam int EI = 2;
  localparam int MD = 1 << MI;
  localparam int ED = 1 << EI;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_entry = '0;
  logic [3:0]   in_err_code = '0;
  logic [MI-1:0] main_tail = '0;
  logic [MI-1:0] main_head;
  logic          main_wr_en;
  logic [MI+2:0] main_wr_addr;
  logic [31:0]   main_wr_data;
  logic [EI-1:0] err_tail = '0;
  logic [EI-1:0] err_head;
  logic          err_wr_en;
  logic [EI+2:0] err_wr_addr;
  logic [31:0]   err_wr_data;

  always #(CLK_P/2) clk = ~clk;

  cmpl_ring_writer #(.MAIN_IDX_W(MI), .ERR_IDX_W(EI), .WORD_W(32),
                     .ENTRY_WORDS(8), .PASS_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_entry(in_entry), .in_err_code(in_err_code),
    .main_tail(main_tail), .main_head(main_head), .main_wr_en(main_wr_en),
    .main_wr_addr(main_wr_addr), .main_wr_data(main_wr_data),
    .err_tail(err_tail), .err_head(err_head), .err_wr_en(err_wr_en),
    .err_wr_addr(err_wr_addr), .err_wr_data(err_wr_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit running = 1'b0;
  bit auto_consume = 1'b0;
  bit acc_seen = 1'b0;

  // reference model state
  int m_head = 0, e_head = 0, m_pass = 0;
  bit          q_ring[$];
  int          q_addr[$];
  logic [31:0] q_data[$];
  int seen_stamp[20];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // consumer that keeps pace with the producer
  always @(negedge clk) if (auto_consume) begin
    main_tail <= main_head;
    err_tail  <= err_head;
  end

  // per-cycle model comparison, sampled mid-way between edges
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (running) begin
        bit exp_ready;
        bit tgt_err;
        bit full_m, full_e;
        full_m = (((m_head + 1) % MD) == int'(main_tail));
        full_e = (((e_head + 1) % ED) == int'(err_tail));
        tgt_err = in_entry[2*32+31];
        exp_ready = (q_ring.size() == 0) && (tgt_err ? !full_e : !full_m);
        chk(in_ready == exp_ready, (q_ring.size() != 0) ? "R9" : "R8",
            "in_ready", in_ready, exp_ready);
        chk(int'(main_head) == m_head, "R3", "main_head", main_head, m_head);
        chk(int'(err_head) == e_head, "R3", "err_head", err_head, e_head);
        if (q_ring.size() != 0) begin
          bit r; int a; logic [31:0] d;
          r = q_ring.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
          if (r) begin
            chk(err_wr_en && !main_wr_en, "R6", "error ring enables",
                {main_wr_en, err_wr_en}, 1);
            chk(int'(err_wr_addr) == a, "R2", "err_wr_addr", err_wr_addr, a);
            chk(err_wr_data[27:0] == d[27:0], "R7", "err_wr_data", err_wr_data, d);
            chk(err_wr_data[31:28] == d[31:28], "R6", "error code", err_wr_data[31:28], d[31:28]);
            if (a % 8 == 7) e_head = (e_head + 1) % ED;
          end else begin
            chk(main_wr_en && !err_wr_en, "R2", "main ring enables",
                {main_wr_en, err_wr_en}, 2);
            chk(int'(main_wr_addr) == a, "R2", "main_wr_addr", main_wr_addr, a);
            chk(main_wr_data[27:0] == d[27:0], "R7", "main_wr_data", main_wr_data, d);
            chk(main_wr_data[31:28] == d[31:28], "R4", "pass stamp", main_wr_data[31:28], d[31:28]);
            if (a % 8 == 7) begin
              if (m_pass < 20) seen_stamp[m_pass] = int'(main_wr_data[31:28]);
              if (m_head == MD - 1) m_pass++;
              m_head = (m_head + 1) % MD;
            end
          end
        end else begin
          chk(!main_wr_en && !err_wr_en, "R2", "idle enables",
              {main_wr_en, err_wr_en}, 0);
        end
        if (in_valid && exp_ready) begin
          int base;
          base = (tgt_err ? e_head : m_head) * 8;
          for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            w = in_entry[k*32 +: 32];
            if (k == 7) w[31:28] = tgt_err ? in_err_code : 4'((m_pass + 1) % 16);
            q_ring.push_back(tgt_err);
            q_addr.push_back(base + k);
            q_data.push_back(w);
          end
          acc_seen = 1'b1;
        end
      end
    end
  end

  task automatic present(input bit err, input logic [3:0] code);
    logic [255:0] e;
    for (int k = 0; k < 8; k++) e[k*32 +: 32] = $urandom;
    e[2*32+31] = err;
    @(negedge clk);
    in_entry    = e;
    in_err_code = code;
    in_valid    = 1'b1;
    acc_seen    = 1'b0;
  endtask

  task automatic send(input bit err, input logic [3:0] code);
    present(err, code);
    do @(posedge clk); while (!acc_seen);
  endtask

  task automatic idle_until_drained();
    @(negedge clk);
    in_valid = 1'b0;
    while (q_ring.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int mh_before;
    for (int i = 0; i < 20; i++) seen_stamp[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #(CLK_P/4 + 1);
    chk(main_head == 0 && err_head == 0, "R1", "heads after reset", {main_head, err_head}, 0);
    chk(!main_wr_en && !err_wr_en, "R1", "enables after reset", {main_wr_en, err_wr_en}, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    running = 1'b1;

    // R8: fill the main ring with the consumer stalled at slot 0
    for (int i = 0; i < MD - 1; i++) send(1'b0, 4'h0);
    present(1'b0, 4'h0);
    repeat (12) @(negedge clk);
    #(CLK_P/4 + 1);
    chk(in_ready == 1'b0, "R8", "main ring full", in_ready, 0);
    // R8: error entries still pass while the main ring is full
    mh_before = int'(main_head);
    for (int i = 0; i < ED - 1; i++) send(1'b1, 4'(i + 5));
    idle_until_drained();
    chk(int'(main_head) == mh_before, "R6", "main head after error entries", main_head, mh_before);
    chk(int'(err_head) == ED - 1, "R3", "error head after fill", err_head, ED - 1);
    present(1'b1, 4'hA);
    repeat (3) @(negedge clk);
    #(CLK_P/4 + 1);
    chk(in_ready == 1'b0, "R8", "error ring full", in_ready, 0);

    // release both rings and stream 16 more passes of the main ring
    auto_consume = 1'b1;
    send(1'b0, 4'h0);
    for (int i = 0; i < 16 * MD; i++) begin
      send(1'b0, 4'h0);
      if (i % 11 == 3) send(1'b1, 4'(i % 16));
    end
    idle_until_drained();

    // R4 / R5: stamps observed per pass
    chk(seen_stamp[0] == 1, "R4", "first traversal stamp", seen_stamp[0], 1);
    chk(seen_stamp[14] == 15, "R5", "stamp before rollover", seen_stamp[14], 15);
    chk(seen_stamp[15] == 0, "R5", "stamp after rollover", seen_stamp[15], 0);
    chk(seen_stamp[16] == 1, "R5", "stamp after rollover plus one", seen_stamp[16], 1);
    for (int p = 1; p <= 16; p++)
      chk(seen_stamp[p][0] != seen_stamp[p-1][0], "R5", "stamp LSB alternation",
          seen_stamp[p], seen_stamp[p-1]);
    chk(main_head == 0, "R3", "main head after full passes", main_head, 0);
    running = 1'b0;
    finish_run();
  end
endmodule